// File: doc/BRIEF.md
# Serial-Bus Ferroelectric-Style Memory Device Controller

This block is the device end of a byte-wide nonvolatile memory that sits on an SPI bus. A bus master lowers chip select, clocks in an 8-bit command code, and then either clocks in address and data bytes or clocks out data bytes. Every byte written lands in the array as soon as its eighth bit arrives, so there is no busy time and no need to poll for completion. A new command can start as soon as chip select has gone high and then low again.

The block runs on a fast system clock and oversamples the bus pins through two-flop synchronisers. Bus bits are taken on serial-clock rising edges, and the data output changes on falling edges. This gives SPI modes 0 and 3 with no mode setting. A write-enable flag guards every state-changing command. The flag is set only by its own command and drops when chip select rises after a disable, status-write or memory-write command. A status byte holds that flag and three protect bits, and a lock bit combined with the write-protect pin can freeze the status byte. The array depth is 2^ADDR_BITS bytes. The default of 10 keeps simulation small, and 18 gives the full 256K x 8 organisation.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the data-output enable is low, the sleep flag is low, and the status byte reads 0x00.
- R2: Bytes move most significant bit first, input bits are taken on serial-clock rising edges and output bits change on falling edges, so transfers work with the clock idling low (mode 0) and idling high (mode 3).
- R3: Command 0x06 sets the write-enable flag, which appears as bit 1 of the status byte. Command 0x05 returns the status byte, repeating it for every further byte clocked while selected.
- R4: The write-enable flag clears on the chip-select rising edge that ends command 0x04, 0x01 or 0x02, and it clears nowhere else.
- R5: Command 0x01 (status write) and command 0x02 (memory write) change no status bit and no array byte while the write-enable flag is clear.
- R6: A status write stores data bits 7, 3 and 2 into the same status bit positions. Data bit 1 has no effect on the write-enable flag, and status bits 6:4 and 0 always read 0.
- R7: A status write is ignored when status bit 7 is set and the write-protect pin is low.
- R8: Command 0x02 is followed by three address bytes, high byte first, of which the low ADDR_BITS bits are used. Each following data byte is stored when its eighth bit arrives, and the address then increments, wrapping from the top address to zero.
- R9: Command 0x03 with three address bytes returns array bytes from that address onward, incrementing and wrapping from the top address to zero.
- R10: The data-output enable is high only in the data phase of commands 0x05 and 0x03. It is low during command and address bytes, during status-write data, and within a few system clocks of chip select going high.
- R11: Chip select going high at any bit aborts the command, and a partly received byte is discarded and never written or decoded.
- R12: Command 0xB9 sets the sleep flag, and the next chip-select falling edge clears it.
- R13: A command may start immediately after the previous one ends, and data written by one command is returned by the very next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial bus clock |
| mosi | input | 1 | Serial data from master |
| wp_n | input | 1 | Active-low write-protect pin |
| miso | output | 1 | Serial data to master |
| miso_oe | output | 1 | Drive enable for miso (high = driven) |
| asleep | output | 1 | Sleep flag |

## Verification
A wrong write-enable flag shows up in the next status read, as a bit-1 mismatch. It also shows up one command later, when a memory or status write is applied that should have been dropped, or dropped when it should have been applied. A misplaced address pointer or bit counter corrupts the very next data byte seen on miso, so read-back right after each write exposes it within one byte time. The output enable is compared at every bit of every transfer, so a phase-tracking error shows at the first bit where the drive window is wrong. Wrap-around, mid-byte aborts, the protect lock and both clock idle levels each get a sequence of their own.

// File: rtl/spi_fram_slave.sv
module spi_fram_slave #(
  parameter int ADDR_BITS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic miso_oe,
  output logic asleep
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'hB9;

  typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_WDATA, PH_RDATA, PH_SRIN, PH_IDLE} phase_t;

  logic [2:0] cs_sy, sck_sy;
  logic [1:0] mosi_sy, wp_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy   <= 3'b111;
      sck_sy  <= 3'b000;
      mosi_sy <= 2'b00;
      wp_sy   <= 2'b11;
    end else begin
      cs_sy   <= {cs_sy[1:0], cs_n};
      sck_sy  <= {sck_sy[1:0], sclk};
      mosi_sy <= {mosi_sy[0], mosi};
      wp_sy   <= {wp_sy[0], wp_n};
    end

  wire cs_s    = cs_sy[1];
  wire cs_rise = cs_sy[1] & ~cs_sy[2];
  wire cs_fall = ~cs_sy[1] & cs_sy[2];
  wire wp_s    = wp_sy[1];
  wire rise    = ~cs_s & sck_sy[1] & ~sck_sy[2];
  wire fall    = ~cs_s & ~sck_sy[1] & sck_sy[2];

  phase_t phase;
  logic [2:0] cnt;
  logic [6:0] rx;
  logic [7:0] tx, op;
  logic [1:0] nab;
  logic [ADDR_BITS-1:0] ptr;
  logic wel, wel_kill, lock;
  logic [1:0] bp;
  logic [7:0] mem [DEPTH];

  wire [7:0] byte_in   = {rx, mosi_sy[1]};
  wire       byte_done = rise && (cnt == 3'd7);
  wire       op_done   = byte_done && (phase == PH_OP);
  wire [7:0] status    = {lock, 3'b000, bp, wel, 1'b0};
  wire       mem_we    = byte_done && (phase == PH_WDATA) && wel;

  assign miso = tx[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_OP;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      op      <= '0;
      nab     <= '0;
      ptr     <= '0;
      miso_oe <= 1'b0;
    end else if (cs_s) begin
      phase   <= PH_OP;
      cnt     <= '0;
      nab     <= '0;
      miso_oe <= 1'b0;
    end else begin
      if (rise) begin
        rx  <= byte_in[6:0];
        cnt <= cnt + 3'd1;
      end
      if (byte_done)
        case (phase)
          PH_OP: begin
            op <= byte_in;
            case (byte_in)
              OP_READ, OP_WRITE: phase <= PH_ADDR;
              OP_RDSR:           phase <= PH_RDATA;
              OP_WRSR:           phase <= PH_SRIN;
              default:           phase <= PH_IDLE;
            endcase
          end
          PH_ADDR: begin
            ptr <= ADDR_BITS'({ptr, byte_in});
            nab <= nab + 2'd1;
            if (nab == 2'd2) phase <= (op == OP_READ) ? PH_RDATA : PH_WDATA;
          end
          PH_WDATA: ptr <= ptr + 1'b1;
          PH_SRIN:  phase <= PH_IDLE;
          default: ;
        endcase
      if (fall && phase == PH_RDATA) begin
        if (cnt == 3'd0) begin
          miso_oe <= 1'b1;
          if (op == OP_READ) begin
            tx  <= mem[ptr];
            ptr <= ptr + 1'b1;
          end else begin
            tx <= status;
          end
        end else begin
          tx <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk)
    if (mem_we) mem[ptr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel      <= 1'b0;
      wel_kill <= 1'b0;
      lock     <= 1'b0;
      bp       <= 2'b00;
      asleep   <= 1'b0;
    end else begin
      if (op_done && byte_in == OP_WREN) wel <= 1'b1;
      if (op_done && (byte_in == OP_WRDI || byte_in == OP_WRSR || byte_in == OP_WRITE))
        wel_kill <= 1'b1;
      if (cs_rise) begin
        if (wel_kill) wel <= 1'b0;
        wel_kill <= 1'b0;
      end
      if (byte_done && phase == PH_SRIN && wel && !(lock && !wp_s)) begin
        lock <= byte_in[7];
        bp   <= byte_in[3:2];
      end
      if (op_done && byte_in == OP_SLEEP) asleep <= 1'b1;
      else if (cs_fall)                   asleep <= 1'b0;
    end

  a_r3_wel_sets_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(cs_s));
  a_r4_wel_clears_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(cs_s));
  a_r5_status_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lock, bp}) |-> $past(wel));
  a_r7_lock_honoured: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({lock, bp}) |-> !($past(lock) && !$past(wp_s)));
  a_r10_oe_only_in_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> phase == PH_RDATA);
  a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> !miso_oe);
  a_r11_counter_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_s) |-> cnt == 3'd0);
  a_r12_wake_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(cs_fall));

endmodule

// File: tb/spi_fram_slave_bench.sv
module spi_fram_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = 6;
  localparam int GAP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, asleep;

  spi_fram_slave #(.ADDR_BITS(AW)) u_spi_fram_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .miso_oe(miso_oe), .asleep(asleep));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic mode3 = 1'b0;
  logic m_wel = 1'b0, m_lock = 1'b0;
  logic [1:0] m_bp = 2'b00;
  logic [7:0] mmem [int];
  logic [7:0] wbuf [$];

  function automatic logic [7:0] exp_sr();
    return {m_lock, 3'b000, m_bp, m_wel, 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, input logic exp_oe, output logic q);
    if (mode3) sclk = 1'b0;
    mosi = b;
    wait_clk(HALF);
    q = miso;
    chk("R10", miso_oe, exp_oe, "output enable at bit");
    sclk = 1'b1;
    wait_clk(HALF);
    if (!mode3) sclk = 1'b0;
  endtask

  task automatic xbits(input logic [7:0] v, input int n, input logic exp_oe, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - n; i--) begin
      logic q;
      bit_io(v[i], exp_oe, q);
      got[i] = q;
    end
  endtask

  task automatic xbyte(input logic [7:0] v, input logic exp_oe, output logic [7:0] got);
    xbits(v, 8, exp_oe, got);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(GAP);
    chk("R10", miso_oe, 1'b0, "output enable after deselect");
  endtask

  task automatic cmd_op(input logic [7:0] op);
    logic [7:0] g;
    cs_lo(); xbyte(op, 1'b0, g); cs_hi();
    if (op == 8'h06) m_wel = 1'b1;
    if (op == 8'h04) m_wel = 1'b0;
  endtask

  task automatic rdsr_check(input string req);
    logic [7:0] g;
    cs_lo();
    xbyte(8'h05, 1'b0, g);
    xbyte(8'h00, 1'b1, g); chk(req, g, exp_sr(), "status byte");
    xbyte(8'h00, 1'b1, g); chk("R3", g, exp_sr(), "status repeat");
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] g;
    cs_lo(); xbyte(8'h01, 1'b0, g); xbyte(v, 1'b0, g); cs_hi();
    if (m_wel && !(m_lock && !wp_n)) begin m_lock = v[7]; m_bp = v[3:2]; end
    m_wel = 1'b0;
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] g;
    xbyte(a[23:16], 1'b0, g); xbyte(a[15:8], 1'b0, g); xbyte(a[7:0], 1'b0, g);
  endtask

  task automatic write_mem(input logic [23:0] a, input int partial_bits);
    logic [7:0] g;
    cs_lo(); xbyte(8'h02, 1'b0, g); send_addr(a);
    foreach (wbuf[i]) begin
      xbyte(wbuf[i], 1'b0, g);
      if (m_wel) mmem[(int'(a[AW-1:0]) + i) % DEPTH] = wbuf[i];
    end
    if (partial_bits > 0) xbits(8'hFF, partial_bits, 1'b0, g);
    cs_hi();
    m_wel = 1'b0;
  endtask

  task automatic read_check(input logic [23:0] a, input int n, input string req);
    logic [7:0] g;
    cs_lo(); xbyte(8'h03, 1'b0, g); send_addr(a);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (int'(a[AW-1:0]) + i) % DEPTH;
      xbyte(8'h00, 1'b1, g);
      if (mmem.exists(ad)) chk(req, g, mmem[ad], $sformatf("read byte at %0h", ad));
    end
    cs_hi();
  endtask

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        nfail++; nchk++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 200000", cyc);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] g;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    chk("R1", miso_oe, 1'b0, "oe after reset");
    chk("R1", asleep, 1'b0, "sleep after reset");
    rdsr_check("R1");

    cmd_op(8'h06); rdsr_check("R3");
    wbuf = '{8'h11, 8'h22};
    write_mem(24'h000010, 0);
    rdsr_check("R4");
    wbuf = '{8'hAA, 8'h55};
    write_mem(24'h000010, 0);
    read_check(24'h000010, 2, "R5");
    wrsr(8'h8C); rdsr_check("R5");

    cmd_op(8'h06); cmd_op(8'h04); rdsr_check("R4");
    cmd_op(8'h06); wrsr(8'hFF); rdsr_check("R6");

    wp_n = 1'b0;
    cmd_op(8'h06); wrsr(8'h00); rdsr_check("R7");
    wp_n = 1'b1;
    cmd_op(8'h06); wrsr(8'h04); rdsr_check("R6");

    cmd_op(8'h06);
    wbuf = '{8'hC1, 8'h3E, 8'h7F, 8'h80};
    write_mem(24'hFC0000 | 24'(DEPTH - 2), 0);
    read_check(24'(DEPTH - 2), 4, "R8");
    read_check(24'(DEPTH - 1), 3, "R9");
    rdsr_check("R4");

    cmd_op(8'h06);
    wbuf = '{8'h5A};
    write_mem(24'h000020, 0);
    read_check(24'h000020, 1, "R13");
    cmd_op(8'h06);
    wbuf = '{8'h5A, 8'hA5};
    write_mem(24'h000020, 0);
    cmd_op(8'h06);
    wbuf = '{8'h66};
    write_mem(24'h000020, 4);
    read_check(24'h000020, 2, "R11");
    rdsr_check("R11");

    cs_lo(); xbits(8'h06, 4, 1'b0, g); cs_hi();
    rdsr_check("R11");

    cmd_op(8'hB9);
    chk("R12", asleep, 1'b1, "sleep after command");
    cs_lo();
    chk("R12", asleep, 1'b0, "sleep after select");
    xbyte(8'h05, 1'b0, g); xbyte(8'h00, 1'b1, g);
    chk("R12", g, exp_sr(), "status after wake");
    cs_hi();

    mode3 = 1'b1; sclk = 1'b1; wait_clk(GAP);
    cmd_op(8'h06); rdsr_check("R2");
    wbuf = '{8'h96, 8'h01, 8'hF0};
    write_mem(24'h000100, 0);
    read_check(24'h000100, 3, "R2");
    rdsr_check("R2");
    mode3 = 1'b0; sclk = 1'b0; wait_clk(GAP);
    read_check(24'h000100, 3, "R2");

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule